// File: doc/BRIEF.md
# Data-Return Sequence and Timeout Monitor

This block sits beside a bus port on a split-transaction bus and watches the data phase of the port's own read-type commands. Each time the port issues a command it records the sequence number under which the responding slave must return data. When a slave raises its send-data strobe, the block compares the sequence value carried with the strobe against the oldest recorded entry. It also catches a strobe that shows up while nothing is outstanding.

When the data-bus slot for the oldest command is reached, a timer starts. If no strobe arrives within 256 counted cycles, the command is considered lost. Cycles in which the bus hold line is asserted are not counted, so a stretched transaction does not trip the timer early. Both kinds of error latch a status bit that stays set until a clear input is pulsed. Each detected error also produces a one-cycle pulse on the fault output.

Top module: `dret_mon`

## Requirements
- R1: Every output is 0 during and after reset, and the queue of expected sequence numbers is empty.
- R2: A strobe with sd_valid_i=1 and sd_seq_i equal to the oldest queued sequence number retires that entry and raises no error.
- R3: A strobe whose sd_seq_i differs from the oldest queued value retires that entry and sets seq_err_o on the following clock edge.
- R4: A strobe while the queue is empty sets seq_err_o on the following clock edge.
- R5: The timer is armed by slot_i while the queue is not empty. After 256 counted cycles with no strobe, tmo_err_o is set and the oldest entry is dropped.
- R6: A cycle with hold_i=1 does not advance the timer, so the timeout arrives 256 plus the number of hold cycles after arming.
- R7: A strobe in the last counted cycle takes priority over the timeout and stops the timer. A later arming starts a full new count of 256.
- R8: seq_err_o and tmo_err_o stay set until clr_i is asserted. If clr_i and a new error coincide, the bit remains set.
- R9: fault_o is high for exactly one cycle after each cycle in which a sequence error or a timeout is detected, and is low otherwise.
- R10: The queue holds DEPTH=4 entries. An issue while it is full is ignored.
- R11: An issue and a strobe in the same cycle both take effect: the strobe is checked against the old head, and the new entry is appended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| clr_i | input | 1 | Clears both sticky error bits |
| issue_i | input | 1 | Port issued a command expecting returned data |
| issue_seq_i | input | SEQ_W | Sequence number expected for that command |
| slot_i | input | 1 | Data-bus slot reached for the oldest outstanding command |
| sd_valid_i | input | 1 | Slave send-data strobe |
| sd_seq_i | input | SEQ_W | Sequence value carried with the strobe |
| hold_i | input | 1 | Bus hold; freezes the timeout count |
| seq_err_o | output | 1 | Sticky illegal-sequence error |
| tmo_err_o | output | 1 | Sticky send-data timeout error |
| fault_o | output | 1 | One-cycle pulse per detected error |

## Verification
The sequence check is swept over every pair of expected and received 4-bit values. This separates a correct comparison from one that ignores bits or is stuck. Orphan strobes, a queue filled past capacity, and same-cycle issue and retire show whether the head entry is tracked and retired in the right order. Timeouts are run with several hold counts, both leading and interleaved, and the bench checks that the error is absent one cycle before 256 plus the hold count and present exactly there. A strobe in the final counted cycle confirms that the strobe wins over the timeout and that the timer restarts from zero.

// File: rtl/dret_mon_pkg.sv
package dret_mon_pkg;
  typedef struct packed {
    logic seq;
    logic tmo;
  } err_evt_t;
endpackage

// File: rtl/dret_seq_queue.sv
module dret_seq_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  slot_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign do_pop  = pop_i & ~empty_o;
  assign do_push = push_i & (~full_o | do_pop);
  assign head_o  = slot_q[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == LAST_PTR) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == LAST_PTR) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic wr_en;
    assign wr_en = do_push && (wr_q == AW'(i));
    always_ff @(posedge clk) begin
      if (wr_en) slot_q[i] <= push_data_i;
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  assert_full_push_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !pop_i) |=> full_o);
endmodule

// File: rtl/dret_timer.sv
module dret_timer #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic stop_i,
  input  logic hold_i,
  output logic expire_o
);
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             count_en;

  assign count_en = armed_q & ~hold_i & ~stop_i;
  assign expire_o = count_en & (cnt_q == LAST);

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (stop_i || expire_o) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (arm_i && !armed_q) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (count_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  assert_hold_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && hold_i && !stop_i) |=> ($stable(cnt_q) && armed_q));
  assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (cnt_q == '0));
endmodule

// File: rtl/dret_mon.sv
module dret_mon #(
  parameter int DEPTH = 4,
  parameter int SEQ_W = 4,
  parameter int LIMIT = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             issue_i,
  input  logic [SEQ_W-1:0] issue_seq_i,
  input  logic             slot_i,
  input  logic             sd_valid_i,
  input  logic [SEQ_W-1:0] sd_seq_i,
  input  logic             hold_i,
  output logic             seq_err_o,
  output logic             tmo_err_o,
  output logic             fault_o
);
  import dret_mon_pkg::*;

  logic [SEQ_W-1:0] head;
  logic             q_empty, q_full, q_pop;
  logic             expire;
  err_evt_t         evt;
  logic             seq_err_d, tmo_err_d, fault_d;

  dret_seq_queue #(.DEPTH(DEPTH), .W(SEQ_W)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push_i(issue_i), .push_data_i(issue_seq_i),
    .pop_i(q_pop), .head_o(head), .empty_o(q_empty), .full_o(q_full)
  );

  dret_timer #(.LIMIT(LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .arm_i(slot_i & ~q_empty), .stop_i(sd_valid_i), .hold_i(hold_i),
    .expire_o(expire)
  );

  always_comb begin
    evt.seq   = sd_valid_i & (q_empty | (sd_seq_i != head));
    evt.tmo   = expire;
    q_pop     = (sd_valid_i & ~q_empty) | expire;
    seq_err_d = (seq_err_o & ~clr_i) | evt.seq;
    tmo_err_d = (tmo_err_o & ~clr_i) | evt.tmo;
    fault_d   = evt.seq | evt.tmo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_err_o <= 1'b0;
      tmo_err_o <= 1'b0;
      fault_o   <= 1'b0;
    end else begin
      seq_err_o <= seq_err_d;
      tmo_err_o <= tmo_err_d;
      fault_o   <= fault_d;
    end
  end

  assert_orphan_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_valid_i && q_empty) |=> (seq_err_o && fault_o));
  assert_mismatch_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_valid_i && !q_empty && sd_seq_i != head) |=> (seq_err_o && fault_o));
  assert_timeout_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (tmo_err_o && fault_o));
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_err_o && !clr_i) |=> seq_err_o);
  assert_fault_backed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (seq_err_o || tmo_err_o));
endmodule

// File: tb/sim_dret_mon.sv
module sim_dret_mon;
  localparam int CLK_P = 10;
  localparam int LIM   = 256;

  logic       clk = 1'b0;
  logic       rst_n, clr, issue, slot, sdv, hold;
  logic [3:0] iseq, sseq;
  logic       seq_err, tmo_err, fault;
  int         checks = 0;
  int         fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  dret_mon #(.DEPTH(4), .SEQ_W(4), .LIMIT(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .issue_i(issue), .issue_seq_i(iseq),
    .slot_i(slot), .sd_valid_i(sdv), .sd_seq_i(sseq), .hold_i(hold),
    .seq_err_o(seq_err), .tmo_err_o(tmo_err), .fault_o(fault)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    clr = 0; issue = 0; slot = 0; sdv = 0; hold = 0; iseq = '0; sseq = '0;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_issue(input logic [3:0] v);
    issue = 1; iseq = v; tick(); issue = 0;
  endtask

  task automatic do_send(input logic [3:0] v);
    sdv = 1; sseq = v; tick(); sdv = 0;
  endtask

  task automatic do_clear();
    clr = 1; tick(); clr = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    tick(); tick();
    chk({seq_err, tmo_err, fault} == 3'b000, "R1", "outputs in reset", {seq_err, tmo_err, fault}, 0);
    @(negedge clk); rst_n = 1;
    tick();
    chk({seq_err, tmo_err, fault} == 3'b000, "R1", "outputs after reset", {seq_err, tmo_err, fault}, 0);
    do_send(4'd0);
    chk(seq_err == 1, "R1", "queue empty after reset", seq_err, 1);
    do_clear();

    // R2 / R3 / R9: sweep of all expected and received values
    for (int e = 0; e < 16; e++) begin
      for (int r = 0; r < 16; r++) begin
        do_issue(4'(e));
        do_send(4'(r));
        if (e == r) begin
          chk(seq_err == 0 && fault == 0, "R2", "match raised error", seq_err, 0);
        end else begin
          chk(seq_err == 1, "R3", "mismatch seq_err", seq_err, 1);
          chk(fault == 1, "R9", "mismatch fault pulse", fault, 1);
        end
        tick();
        chk(fault == 0, "R9", "fault not single cycle", fault, 0);
        chk(seq_err == (e != r), "R8", "sticky seq_err", seq_err, int'(e != r));
        do_clear();
        chk(seq_err == 0, "R8", "clear seq_err", seq_err, 0);
      end
    end

    // R4 orphan
    do_send(4'd9);
    chk(seq_err == 1 && fault == 1, "R4", "orphan strobe", seq_err, 1);
    // R8: clear together with a new error keeps the bit
    clr = 1; sdv = 1; sseq = 4'd2; tick(); clr = 0; sdv = 0;
    chk(seq_err == 1, "R8", "clear with new error", seq_err, 1);
    do_clear();

    // R10: fill past capacity
    for (int i = 1; i <= 5; i++) do_issue(4'(i));
    for (int i = 1; i <= 4; i++) begin
      do_send(4'(i));
      chk(seq_err == 0, "R10", "in-order drain", seq_err, 0);
    end
    do_send(4'd5);
    chk(seq_err == 1, "R10", "fifth issue not dropped", seq_err, 1);
    do_clear();

    // R11: issue and strobe in the same cycle
    do_issue(4'd6);
    issue = 1; iseq = 4'd7; sdv = 1; sseq = 4'd6; tick(); issue = 0; sdv = 0;
    chk(seq_err == 0, "R11", "simultaneous head match", seq_err, 0);
    do_send(4'd7);
    chk(seq_err == 0, "R11", "appended entry", seq_err, 0);
    do_send(4'd7);
    chk(seq_err == 1, "R11", "queue drained", seq_err, 1);
    do_clear();

    // R5 / R6: timeouts with leading hold cycles
    for (int k = 0; k < 4; k++) begin
      int h;
      h = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 5 : 17;
      do_issue(4'd3);
      slot = 1; tick(); slot = 0;
      hold = 1;
      for (int i = 0; i < h; i++) tick();
      hold = 0;
      for (int i = 0; i < LIM - 1; i++) tick();
      chk(tmo_err == 0, "R6", "early timeout", tmo_err, 0);
      tick();
      chk(tmo_err == 1 && fault == 1, "R5", "timeout at 256+holds", tmo_err, 1);
      tick();
      chk(fault == 0, "R9", "timeout fault single cycle", fault, 0);
      do_send(4'd3);
      chk(seq_err == 1, "R5", "head dropped on timeout", seq_err, 1);
      do_clear();
    end

    // R6: interleaved hold cycles (10 holds)
    do_issue(4'd4);
    slot = 1; tick(); slot = 0;
    for (int i = 0; i < 20; i++) begin hold = (i % 2 == 0); tick(); end
    hold = 0;
    for (int i = 0; i < LIM - 11; i++) tick();
    chk(tmo_err == 0, "R6", "interleaved hold early", tmo_err, 0);
    tick();
    chk(tmo_err == 1, "R6", "interleaved hold timeout", tmo_err, 1);
    do_clear();

    // R7: strobe in last counted cycle wins, restart is a full count
    do_issue(4'd9);
    slot = 1; tick(); slot = 0;
    for (int i = 0; i < LIM - 1; i++) tick();
    do_send(4'd9);
    chk(tmo_err == 0 && seq_err == 0, "R7", "last-cycle strobe", tmo_err, 0);
    for (int i = 0; i < 300; i++) tick();
    chk(tmo_err == 0, "R7", "timer stopped", tmo_err, 0);
    do_issue(4'd1);
    slot = 1; tick(); slot = 0;
    for (int i = 0; i < LIM - 1; i++) tick();
    chk(tmo_err == 0, "R7", "restart early", tmo_err, 0);
    tick();
    chk(tmo_err == 1, "R7", "restart full count", tmo_err, 1);
    do_clear();
    chk(tmo_err == 0, "R8", "clear tmo_err", tmo_err, 0);

    // R5: slot with empty queue does not arm
    slot = 1; tick(); slot = 0;
    for (int i = 0; i < LIM + 4; i++) tick();
    chk(tmo_err == 0, "R5", "slot on empty queue", tmo_err, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule